// File: doc/BRIEF.md
# Serial Interrupt Slot Driver

This block lets a peripheral raise one interrupt towards a host over a shared, open-drain serial interrupt line. A register file supplies an interrupt number and an active-high request level. The block follows each serial interrupt cycle on the line: the start pulse, two turnaround clocks, a fixed run of three-clock data frames and a stop pulse. If the request is active when the frame belonging to the latched number begins, the block pulls the line low in that frame's first clock.

The host picks the mode for the next cycle through the length of the stop pulse. In continuous mode only the host opens cycles. In quiet mode the block may open a cycle itself by pulling the idle line low for a single clock while its request is high; the host then carries the start pulse on. The line is modelled as a drive enable plus a drive value, and the pad resolves them into the wired-AND bus. All logic runs on the rising edge of one clock. The line value on the bus during a clock is taken at the edge that ends that clock.

Top module: `serirq_slot_driver`

## Requirements
- R1: After reset the drive enable `lineOe` is 0 and the block is in continuous mode. While idle it then never drives, even with `irqReq` high.
- R2: A cycle opens when the idle line is seen low. The first high clock after the start pulse and the clock after it are turnaround clocks. Data frame 0 begins in the next clock, and data frame n begins 3·n clocks after data frame 0. There are `NUM_FRAMES` frames.
- R3: In a signalled frame the block drives low (`lineOe`=1, `lineOut`=0) in the first (sample) clock and drives high (`lineOe`=1, `lineOut`=1) in the second (recovery) clock. It releases the line (`lineOe`=0) in the third (turnaround) clock.
- R4: `irqNum` is latched at the edge that ends the first turnaround clock of the start frame. Changes to `irqNum` after that edge do not change which frame is signalled in the current cycle.
- R5: `irqReq` is evaluated only at the edge that begins the sample clock of the frame whose index equals the latched number. Changes during that frame's recovery clock do not alter the recovery drive.
- R6: The interrupt number is not filtered. Numbers 0 and 2 are signalled in frames 0 and 2 like any other number.
- R7: The request is a level. Every cycle signals the frame again while `irqReq` stays high, and a frame with `irqReq` low at its sample edge is not driven.
- R8: In continuous mode the block never drives the idle line.
- R9: A stop pulse of at most `STOP_QUIET_MAX` clocks low (2 by default) selects quiet mode for the following cycles. A longer stop pulse selects continuous mode. The mode takes effect from the first clock after the stop pulse.
- R10: In quiet mode, an idle line seen high with `irqReq` high at the same edge makes the block drive the line low for exactly one clock. That clock counts as the start of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| lineIn | input | 1 | Resolved level of the serial interrupt line |
| irqNum | input | IRQ_W | Interrupt number, selects the data frame |
| irqReq | input | 1 | Interrupt request level, active high |
| lineOe | output | 1 | Drive enable for the open-drain line |
| lineOut | output | 1 | Value driven when `lineOe` is 1 |

## Verification
The drive for any clock is registered at the edge that opens that clock. A request seen at the edge closing an idle clock shows up as the quiet-mode start pulse one clock later. A request seen at the edge closing the second turnaround clock or a frame's third clock decides that frame's sample and recovery drive. The bench owns the host side of the bus, so it knows in advance which clock is the start, turnaround, sample, recovery or stop. At every falling edge it compares the outputs with values computed from that schedule and from the request it applied one clock earlier, and only then applies the line and request for the current clock.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_TURN,
    ST_FRAME,
    ST_STOPWAIT,
    ST_STOPLOW
  } cycleState_t;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic kickStart;     // quiet-mode self start: drive low next clock
    logic latchNum;      // capture interrupt number
    logic sampleEnter;   // next clock is a sample clock (slotIdx valid)
    logic recoveryEnter; // next clock is a recovery clock
  } strobe_t;

endpackage

// File: rtl/serirq_ctrl.sv
module serirq_ctrl
  import serirq_pkg::*;
#(
  parameter int NUM_FRAMES     = 17,
  parameter int STOP_QUIET_MAX = 2,
  parameter int FW             = $clog2(NUM_FRAMES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lineIn,
  input  logic          irqReq,
  output strobe_t       strobes,
  output logic [FW-1:0] slotIdx,
  output logic          quietMode
);

  localparam int SW = $clog2(STOP_QUIET_MAX + 2);
  localparam logic [SW-1:0] STOP_SAT  = SW'(STOP_QUIET_MAX + 1);
  localparam logic [SW-1:0] STOP_LIM  = SW'(STOP_QUIET_MAX);
  localparam logic [FW-1:0] LAST_SLOT = FW'(NUM_FRAMES - 1);

  cycleState_t state, stateD;
  logic [1:0]    phase, phaseD;
  logic [FW-1:0] frame, frameD;
  logic [SW-1:0] stopCnt, stopCntD;
  logic          quietD;

  always_comb begin
    stateD   = state;
    phaseD   = phase;
    frameD   = frame;
    stopCntD = stopCnt;
    quietD   = quietMode;
    strobes  = '0;
    case (state)
      ST_IDLE: begin
        if (!lineIn) begin
          stateD = ST_START;
        end else if (quietMode && irqReq) begin
          strobes.kickStart = 1'b1;
        end
      end
      ST_START: begin
        if (lineIn) begin
          stateD           = ST_TURN;
          strobes.latchNum = 1'b1;
        end
      end
      ST_TURN: begin
        stateD              = ST_FRAME;
        phaseD              = 2'd0;
        frameD              = '0;
        strobes.sampleEnter = 1'b1;
      end
      ST_FRAME: begin
        case (phase)
          2'd0: begin
            phaseD                = 2'd1;
            strobes.recoveryEnter = 1'b1;
          end
          2'd1: phaseD = 2'd2;
          default: begin
            if (frame == LAST_SLOT) begin
              stateD = ST_STOPWAIT;
            end else begin
              frameD              = frame + 1'b1;
              phaseD              = 2'd0;
              strobes.sampleEnter = 1'b1;
            end
          end
        endcase
      end
      ST_STOPWAIT: begin
        if (!lineIn) begin
          stateD   = ST_STOPLOW;
          stopCntD = SW'(1);
        end
      end
      ST_STOPLOW: begin
        if (!lineIn) begin
          if (stopCnt != STOP_SAT) stopCntD = stopCnt + 1'b1;
        end else begin
          stateD = ST_IDLE;
          quietD = (stopCnt <= STOP_LIM);
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign slotIdx = frameD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= 2'd0;
      frame     <= '0;
      stopCnt   <= '0;
      quietMode <= 1'b0;
    end else begin
      state     <= stateD;
      phase     <= phaseD;
      frame     <= frameD;
      stopCnt   <= stopCntD;
      quietMode <= quietD;
    end
  end

endmodule

// File: rtl/serirq_datapath.sv
module serirq_datapath
  import serirq_pkg::*;
#(
  parameter int IRQ_W = 4,
  parameter int FW    = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [FW-1:0]    slotIdx,
  input  logic [IRQ_W-1:0] irqNum,
  input  logic             irqReq,
  output logic             lineOe,
  output logic             lineOut
);

  logic [IRQ_W-1:0] irqLatched;
  logic             slotHit;
  logic             slotMatch;

  assign slotMatch = (slotIdx == FW'(irqLatched)) && irqReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqLatched <= '0;
      slotHit    <= 1'b0;
      lineOe     <= 1'b0;
      lineOut    <= 1'b1;
    end else begin
      if (strobes.latchNum) irqLatched <= irqNum;
      lineOe  <= 1'b0;
      lineOut <= 1'b1;
      if (strobes.kickStart) begin
        lineOe  <= 1'b1;
        lineOut <= 1'b0;
      end
      if (strobes.sampleEnter) begin
        slotHit <= slotMatch;
        lineOe  <= slotMatch;
        lineOut <= 1'b0;
      end
      if (strobes.recoveryEnter) begin
        lineOe  <= slotHit;
        lineOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/serirq_slot_driver.sv
module serirq_slot_driver
  import serirq_pkg::*;
#(
  parameter int IRQ_W          = 4,
  parameter int NUM_FRAMES     = 17,
  parameter int STOP_QUIET_MAX = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic [IRQ_W-1:0] irqNum,
  input  logic             irqReq,
  output logic             lineOe,
  output logic             lineOut
);

  localparam int FW = $clog2(NUM_FRAMES);

  strobe_t       strobes;
  logic [FW-1:0] slotIdx;
  logic          quietMode;

  serirq_ctrl #(
    .NUM_FRAMES    (NUM_FRAMES),
    .STOP_QUIET_MAX(STOP_QUIET_MAX),
    .FW            (FW)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .irqReq   (irqReq),
    .strobes  (strobes),
    .slotIdx  (slotIdx),
    .quietMode(quietMode)
  );

  serirq_datapath #(
    .IRQ_W(IRQ_W),
    .FW   (FW)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .slotIdx(slotIdx),
    .irqNum (irqNum),
    .irqReq (irqReq),
    .lineOe (lineOe),
    .lineOut(lineOut)
  );

endmodule

// File: rtl/serirq_slot_driver_chk.sv
module serirq_slot_driver_chk
  import serirq_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    lineOe,
  input logic    lineOut,
  input logic    quietMode,
  input strobe_t strobes
);

  AST_LOW_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (lineOe && !lineOut) |=> !(lineOe && !lineOut)); // R3

  AST_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (lineOe && lineOut) |-> $past(lineOe && !lineOut)); // R3

  AST_HIGH_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (lineOe && lineOut) |=> !lineOe); // R3

  AST_KICK_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.kickStart |=> (lineOe && !lineOut)); // R10

  AST_SELF_LOW_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (lineOe && !lineOut && !$past(strobes.sampleEnter)) |-> $past(quietMode)); // R8

endmodule

bind serirq_slot_driver serirq_slot_driver_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .lineOe   (lineOe),
  .lineOut  (lineOut),
  .quietMode(quietMode),
  .strobes  (strobes)
);

// File: tb/tb_serirq_slot_driver.sv
module tb_serirq_slot_driver;

  localparam int CLK_PERIOD = 10;
  localparam int NFR        = 17;

  logic       clk = 1'b0;
  logic       rstN;
  logic       hostLow;
  logic [3:0] irqNum;
  logic       irqReq;
  logic       lineOe;
  logic       lineOut;
  logic       lineIn;

  int checks   = 0;
  int failures = 0;
  bit quietExp = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // wired-AND bus: host and block both pull low
  assign lineIn = ~(hostLow | (lineOe & ~lineOut));

  serirq_slot_driver dut (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .irqNum (irqNum),
    .irqReq (irqReq),
    .lineOe (lineOe),
    .lineOut(lineOut)
  );

  // check this clock's outputs at its falling edge, then apply this clock's bus/request
  task automatic step(input bit hl, input bit rq, input bit expOe, input bit expOut,
                      input string tag);
    @(negedge clk);
    checks++;
    if (lineOe !== expOe || (expOe && lineOut !== expOut)) begin
      failures++;
      $display("FAIL %s: oe=%0b out=%0b expected oe=%0b out=%0b",
               tag, lineOe, lineOut, expOe, expOut);
    end
    hostLow = hl;
    irqReq  = rq;
  endtask

  function automatic bit pickReq(input int mode);
    if (mode == 2) return 1'($urandom % 2);
    return (mode == 1);
  endfunction

  task automatic idleSteps(input int n, input int reqMode);
    for (int i = 0; i < n; i++) step(1'b0, pickReq(reqMode), 1'b0, 1'b1, "R8 idle no drive");
  endtask

  // one full cycle with the bench acting as host
  task automatic runCycle(input int startLen, input int stopLen, input logic [3:0] num,
                          input logic [3:0] numLater, input int reqMode, input bit kicked);
    bit hit;
    for (int i = 0; i < startLen; i++) begin
      if (i == 0 && kicked) step(1'b0, pickReq(reqMode), 1'b1, 1'b0, "R10 self start pulse");
      else                  step(1'b1, pickReq(reqMode), 1'b0, 1'b1, "R10 R2 start frame");
    end
    step(1'b0, pickReq(reqMode), 1'b0, 1'b1, "R2 turnaround0");
    irqNum = num;
    step(1'b0, pickReq(reqMode), 1'b0, 1'b1, "R4 turnaround1");
    irqNum = numLater;
    for (int f = 0; f < NFR; f++) begin
      hit = (f == int'(num)) && irqReq;
      step(1'b0, pickReq(reqMode), hit, 1'b0, "R5 R6 R7 sample clock");
      step(1'b0, pickReq(reqMode), hit, 1'b1, "R3 recovery clock");
      step(1'b0, pickReq(reqMode), 1'b0, 1'b1, "R3 turnaround clock");
    end
    for (int i = 0; i < stopLen; i++) step(1'b1, pickReq(reqMode), 1'b0, 1'b1, "R9 stop");
    step(1'b0, pickReq(reqMode), 1'b0, 1'b1, "R9 stop release");
    quietExp = (stopLen <= 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    rstN = 1'b0; hostLow = 1'b0; irqReq = 1'b0; irqNum = 4'd0;
    repeat (3) @(negedge clk);
    checks++;
    if (lineOe !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: oe=%0b expected oe=0", lineOe);
    end
    rstN = 1'b1;
    // R1: continuous after reset, no self start even with request high
    idleSteps(6, 1);

    // directed: slot 0, slot 2 (R6), last slot, late change (R4), request low (R7)
    runCycle(4, 3, 4'd0, 4'd0, 1, 1'b0);
    runCycle(6, 3, 4'd2, 4'd2, 1, 1'b0);
    runCycle(5, 3, 4'd15, 4'd15, 1, 1'b0);
    runCycle(4, 3, 4'd7, 4'd3, 1, 1'b0);
    runCycle(4, 3, 4'd5, 4'd5, 0, 1'b0);
    runCycle(8, 3, 4'd11, 4'd1, 2, 1'b0);

    // random continuous cycles
    for (int k = 0; k < 20; k++) begin
      runCycle(4 + int'($urandom % 5), 3, 4'($urandom), 4'($urandom), int'($urandom % 3), 1'b0);
      idleSteps(int'($urandom % 3), int'($urandom % 3));
    end
    idleSteps(3, 1); // R8

    // R9: short stop selects quiet mode
    runCycle(4, 2, 4'd6, 4'd6, 1, 1'b0);
    idleSteps(3, 0);                                  // R10 no start while request low
    step(1'b0, 1'b1, 1'b0, 1'b1, "R10 arm");
    runCycle(5, 2, 4'd9, 4'd9, 1, 1'b1);              // R10 self-started cycle
    step(1'b0, 1'b1, 1'b0, 1'b1, "R7 R10 rearm");     // level still high: start again
    runCycle(4, 3, 4'd4, 4'd4, 1, 1'b1);              // R9 long stop back to continuous
    idleSteps(5, 1);                                  // R8 R9 no start in continuous

    // random mode mix
    for (int k = 0; k < 12; k++) begin
      int sl;
      sl = 2 + int'($urandom % 2);
      if (quietExp && ($urandom % 2) == 1) begin
        step(1'b0, 1'b1, 1'b0, 1'b1, "R10 arm");
        runCycle(4 + int'($urandom % 4), sl, 4'($urandom), 4'($urandom), 2, 1'b1);
      end else if (quietExp) begin
        idleSteps(2, 0);
        runCycle(4 + int'($urandom % 4), sl, 4'($urandom), 4'($urandom), 2, 1'b0);
      end else begin
        idleSteps(2, 2);
        runCycle(4 + int'($urandom % 4), sl, 4'($urandom), 4'($urandom), 2, 1'b0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule